// File: doc/BRIEF.md
# Serial Management Register Slave for a 10/100 Ethernet PHY

This block is the management end of a two-wire serial bus (clock MDC, bidirectional data MDIO) inside a 10/100 Ethernet physical-layer device. It runs entirely on MDC. A station manager sends a frame made of a run of ones, a start pattern, an opcode, a 5-bit device address, a 5-bit register address, a 2-bit turnaround and 16 data bits. The slave accepts the frame only when the address matches the one it latched from strap pins when hardware reset was released. It then either loads a register or returns one by driving MDIO through an output enable.

The register file holds a control word, whose bits leave the block as control outputs (soft reset, isolate, loopback, 100 Mb/s speed, full duplex). It also holds a read-only capability and status word, two identifier words, an advertisement word, a compact status word that gathers all link state into one read, and a word that reports the latched device address. Link, negotiation, jabber, remote-fault, speed and duplex status arrive as plain inputs.

The frame engine is a state machine with states HUNT (count consecutive ones), START (expect the second start bit), OPC (two opcode bits), PHYAD (five address bits), REGAD (five register bits), TURN (two turnaround bits) and DATA (sixteen data bits). Its transitions are: HUNT to START on a zero after a full preamble; START to OPC on a one, or back to HUNT on a zero; OPC to PHYAD on a valid opcode, or to HUNT on an invalid one; PHYAD to REGAD; REGAD to TURN; TURN to DATA; and DATA back to HUNT after the sixteenth bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is taken only if at least 32 consecutive ones were sampled on MDIO right before its start bit 0. After any frame, the count starts again from zero. A frame preceded by 31 ones has no effect.
- R2: The block responds only when the frame's 5-bit device address equals the latched address. Any other address produces no write and never asserts `mdio_oe`.
- R3: The device address is captured from `strap_phy_addr` when `rst_n` is released. Later strap changes have no effect. Register 0x19 returns the address in bits 4:0 and zeros above.
- R4: `mdio_oe` is low while hunting for a preamble, through the start, opcode, address and register fields and the first turnaround bit, and for the whole of any write frame.
- R5: On a read, the slave drives MDIO low for the second turnaround bit. It then drives the 16 register bits MSB first, each changing on a rising MDC edge. It releases MDIO on the edge after the last bit. The opcode is 10 for read and 01 for write.
- R6: Control register 0x00 maps bit 14 to loopback, bit 13 to 100 Mb/s speed, bit 12 to negotiation enable, bit 10 to isolate and bit 8 to full duplex. All other bits read 0 when no soft reset is running. The reset value is 0x3000 (0x3400 when isolate is forced), and the control outputs follow the stored bits.
- R7: Writing 1 to bit 15 of register 0x00 starts a soft reset that lasts RST_CYCLES MDC cycles (64 by default). During the reset, bit 15 reads 1, `ctl_soft_rst` is high, and the control and advertisement registers hold their reset values. Bit 15 then clears itself.
- R8: When the latched address is 00000, isolate (bit 10 of 0x00) is 1 after a hardware or soft reset. It can still be cleared by a write.
- R9: Register 0x01 is read-only. Its value is 0x7809 with bit 5 = negotiation complete, bit 4 = remote fault, bit 2 = link and bit 1 = jabber added.
- R10: Register 0x10 returns bit 0 link, bit 1 speed is 10 Mb/s, bit 2 full duplex, bit 3 loopback (from control bit 14), bit 4 negotiation complete, bit 5 jabber and bit 6 remote fault, with zeros above.
- R11: Addresses with no register read 0x0000. Writes to them, and to 0x01 and 0x19, have no effect.
- R12: Registers 0x02 and 0x03 return the parameters ID_HI (0x0A5C) and ID_LO (0x3E21). Register 0x04 is fully writable and resets to 0x01E1.
- R13: A frame whose opcode is 00 or 11 is dropped and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Active-low hardware reset |
| strap_phy_addr | input | 5 | Strapped device address, captured at reset release |
| mdio_i | input | 1 | Resolved level of the MDIO line |
| mdio_o | output | 1 | Value the slave drives onto MDIO |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| st_link | input | 1 | Link is up |
| st_an_done | input | 1 | Auto-negotiation complete |
| st_jabber | input | 1 | Jabber detected |
| st_rfault | input | 1 | Remote fault detected |
| st_speed100 | input | 1 | Link runs at 100 Mb/s |
| st_full_duplex | input | 1 | Link runs full duplex |
| ctl_soft_rst | output | 1 | Soft reset in progress |
| ctl_isolate | output | 1 | Isolate the MAC-side interface |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | Forced speed select, 1 = 100 Mb/s |
| ctl_full_duplex | output | 1 | Forced duplex select, 1 = full |

## Verification
The bench targets the edges of frame acceptance. A preamble one bit too short must be rejected, which a design that counts idle ones loosely or off by one would accept. A foreign address must leave the line undriven, which a design that only gates the write would get wrong by answering reads and colliding with another device. Invalid opcodes must be dropped. The read turnaround is checked bit by bit, since a one-cycle slip would put a data bit in place of the low turnaround bit or hold the line a cycle too long. The soft reset is read back while it runs and again after it ends, which exposes a bit that never self-clears or a register file not returned to its defaults. A forced isolate is checked for a zero strap address after both kinds of reset.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPC,
        ST_PHYAD,
        ST_REGAD,
        ST_TURN,
        ST_DATA
    } mf_state_t;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    localparam logic [4:0] RA_CTRL   = 5'h00;
    localparam logic [4:0] RA_STAT   = 5'h01;
    localparam logic [4:0] RA_ID_HI  = 5'h02;
    localparam logic [4:0] RA_ID_LO  = 5'h03;
    localparam logic [4:0] RA_ADV    = 5'h04;
    localparam logic [4:0] RA_QSTAT  = 5'h10;
    localparam logic [4:0] RA_PHYCTL = 5'h19;

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int AW      = 5,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_i,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          mdio_o,
    output logic          mdio_oe
);
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int CW  = $clog2(DW);

    mf_state_t      state, state_nx;
    logic [CW-1:0]  bit_cnt;
    logic [PCW-1:0] ones_cnt;
    logic [1:0]     opc;
    logic [AW-1:0]  phy_sr;
    logic [AW-1:0]  reg_sr;
    logic [DW-1:0]  data_sr;
    logic [DW-1:0]  tx_sr;
    logic           hit;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (!mdio_i && ones_cnt == PCW'(PRE_LEN)) state_nx = ST_START;
            ST_START: state_nx = mdio_i ? ST_OPC : ST_HUNT;
            ST_OPC:   if (bit_cnt == CW'(1))
                          state_nx = ({opc[0], mdio_i} == OP_RD || {opc[0], mdio_i} == OP_WR)
                                     ? ST_PHYAD : ST_HUNT;
            ST_PHYAD: if (bit_cnt == CW'(AW - 1)) state_nx = ST_REGAD;
            ST_REGAD: if (bit_cnt == CW'(AW - 1)) state_nx = ST_TURN;
            ST_TURN:  if (bit_cnt == CW'(1))      state_nx = ST_DATA;
            ST_DATA:  if (bit_cnt == CW'(DW - 1)) state_nx = ST_HUNT;
            default:  state_nx = ST_HUNT;
        endcase
    end

    // state register with bit and preamble counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            bit_cnt  <= '0;
            ones_cnt <= '0;
        end else begin
            state   <= state_nx;
            bit_cnt <= (state_nx != state || state == ST_HUNT) ? '0 : bit_cnt + CW'(1);
            if (state == ST_HUNT && mdio_i)
                ones_cnt <= (ones_cnt == PCW'(PRE_LEN)) ? ones_cnt : ones_cnt + PCW'(1);
            else
                ones_cnt <= '0;
        end
    end

    // field capture and MDIO drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc     <= '0;
            phy_sr  <= '0;
            reg_sr  <= '0;
            data_sr <= '0;
            tx_sr   <= '0;
            hit     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_HUNT, ST_START: ;
                ST_OPC:   opc <= {opc[0], mdio_i};
                ST_PHYAD: begin
                    phy_sr <= {phy_sr[AW-2:0], mdio_i};
                    if (bit_cnt == CW'(AW - 1))
                        hit <= ({phy_sr[AW-2:0], mdio_i} == my_addr);
                end
                ST_REGAD: reg_sr <= {reg_sr[AW-2:0], mdio_i};
                ST_TURN: begin
                    if (bit_cnt == CW'(0)) begin
                        if (hit && opc == OP_RD) begin
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                            tx_sr   <= rd_data;
                        end
                    end else if (mdio_oe) begin
                        mdio_o <= tx_sr[DW-1];
                        tx_sr  <= {tx_sr[DW-2:0], 1'b0};
                    end
                end
                ST_DATA: begin
                    data_sr <= {data_sr[DW-2:0], mdio_i};
                    if (mdio_oe) begin
                        if (bit_cnt == CW'(DW - 1)) begin
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b0;
                        end else begin
                            mdio_o <= tx_sr[DW-1];
                            tx_sr  <= {tx_sr[DW-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign reg_addr = reg_sr;
    assign wr_data  = {data_sr[DW-2:0], mdio_i};
    assign wr_en    = (state == ST_DATA) && (bit_cnt == CW'(DW - 1)) && (opc == OP_WR) && hit;

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_HUNT, ST_START, ST_OPC, ST_PHYAD, ST_REGAD}) |-> !mdio_oe);

    // R2
    drive_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (hit && opc == OP_RD));

    // R1
    preamble_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> ($past(state) == ST_HUNT && $past(ones_cnt) == PCW'(PRE_LEN)));

endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int          AW          = 5,
    parameter int          DW          = 16,
    parameter int          RST_CYCLES  = 64,
    parameter logic [15:0] ID_HI       = 16'h0A5C,
    parameter logic [15:0] ID_LO       = 16'h3E21,
    parameter logic [15:0] ADV_DEFAULT = 16'h01E1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] strap_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          st_link,
    input  logic          st_an_done,
    input  logic          st_jabber,
    input  logic          st_rfault,
    input  logic          st_speed100,
    input  logic          st_full_duplex,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] phy_addr,
    output logic          ctl_soft_rst,
    output logic          ctl_isolate,
    output logic          ctl_loopback,
    output logic          ctl_speed100,
    output logic          ctl_full_duplex
);
    localparam int SCW = $clog2(RST_CYCLES + 1);

    logic [SCW-1:0] srst_cnt;
    logic           an_en;
    logic [DW-1:0]  adv;
    logic           busy;

    assign busy         = (srst_cnt != '0);
    assign ctl_soft_rst = busy;

    // address strap follows the pins while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phy_addr <= strap_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_cnt        <= '0;
            ctl_loopback    <= 1'b0;
            ctl_speed100    <= 1'b1;
            an_en           <= 1'b1;
            ctl_isolate     <= (strap_addr == '0);
            ctl_full_duplex <= 1'b0;
            adv             <= DW'(ADV_DEFAULT);
        end else if (busy) begin
            srst_cnt        <= srst_cnt - SCW'(1);
            ctl_loopback    <= 1'b0;
            ctl_speed100    <= 1'b1;
            an_en           <= 1'b1;
            ctl_isolate     <= (phy_addr == '0);
            ctl_full_duplex <= 1'b0;
            adv             <= DW'(ADV_DEFAULT);
        end else if (wr_en && reg_addr == AW'(RA_CTRL)) begin
            if (wr_data[15]) begin
                srst_cnt        <= SCW'(RST_CYCLES);
                ctl_loopback    <= 1'b0;
                ctl_speed100    <= 1'b1;
                an_en           <= 1'b1;
                ctl_isolate     <= (phy_addr == '0);
                ctl_full_duplex <= 1'b0;
                adv             <= DW'(ADV_DEFAULT);
            end else begin
                ctl_loopback    <= wr_data[14];
                ctl_speed100    <= wr_data[13];
                an_en           <= wr_data[12];
                ctl_isolate     <= wr_data[10];
                ctl_full_duplex <= wr_data[8];
            end
        end else if (wr_en && reg_addr == AW'(RA_ADV)) begin
            adv <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            AW'(RA_CTRL):   rd_data = DW'({busy, ctl_loopback, ctl_speed100, an_en, 1'b0,
                                           ctl_isolate, 1'b0, ctl_full_duplex, 8'h00});
            AW'(RA_STAT):   rd_data = DW'({1'b0, 4'hF, 5'b0, st_an_done, st_rfault, 1'b1,
                                           st_link, st_jabber, 1'b1});
            AW'(RA_ID_HI):  rd_data = DW'(ID_HI);
            AW'(RA_ID_LO):  rd_data = DW'(ID_LO);
            AW'(RA_ADV):    rd_data = adv;
            AW'(RA_QSTAT):  rd_data = DW'({st_rfault, st_jabber, st_an_done, ctl_loopback,
                                           st_full_duplex, ~st_speed100, st_link});
            AW'(RA_PHYCTL): rd_data = DW'(phy_addr);
            default:        rd_data = '0;
        endcase
    end

    // R7
    srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ctl_loopback && ctl_speed100 && !ctl_full_duplex && adv == DW'(ADV_DEFAULT)));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(phy_addr));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int          PRE_LEN     = 32,
    parameter int          RST_CYCLES  = 64,
    parameter logic [15:0] ID_HI       = 16'h0A5C,
    parameter logic [15:0] ID_LO       = 16'h3E21,
    parameter logic [15:0] ADV_DEFAULT = 16'h01E1
) (
    input  logic       mdc,
    input  logic       rst_n,
    input  logic [4:0] strap_phy_addr,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       st_link,
    input  logic       st_an_done,
    input  logic       st_jabber,
    input  logic       st_rfault,
    input  logic       st_speed100,
    input  logic       st_full_duplex,
    output logic       ctl_soft_rst,
    output logic       ctl_isolate,
    output logic       ctl_loopback,
    output logic       ctl_speed100,
    output logic       ctl_full_duplex
);
    localparam int AW = 5;
    localparam int DW = 16;

    logic [AW-1:0] phy_addr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] wr_data;
    logic          wr_en;

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .AW      (AW),
        .DW      (DW)
    ) u_fsm (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_i   (mdio_i),
        .my_addr  (phy_addr),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mdio_phy_regs #(
        .AW          (AW),
        .DW          (DW),
        .RST_CYCLES  (RST_CYCLES),
        .ID_HI       (ID_HI),
        .ID_LO       (ID_LO),
        .ADV_DEFAULT (ADV_DEFAULT)
    ) u_regs (
        .clk             (mdc),
        .rst_n           (rst_n),
        .strap_addr      (strap_phy_addr),
        .reg_addr        (reg_addr),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .st_link         (st_link),
        .st_an_done      (st_an_done),
        .st_jabber       (st_jabber),
        .st_rfault       (st_rfault),
        .st_speed100     (st_speed100),
        .st_full_duplex  (st_full_duplex),
        .rd_data         (rd_data),
        .phy_addr        (phy_addr),
        .ctl_soft_rst    (ctl_soft_rst),
        .ctl_isolate     (ctl_isolate),
        .ctl_loopback    (ctl_loopback),
        .ctl_speed100    (ctl_speed100),
        .ctl_full_duplex (ctl_full_duplex)
    );

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
    localparam int          CLK_PERIOD = 20;
    localparam int          WD_LIMIT   = 150000;
    localparam logic [15:0] TB_ID_HI   = 16'h0A5C;
    localparam logic [15:0] TB_ID_LO   = 16'h3E21;
    localparam logic [4:0]  PHYA       = 5'h0B;
    localparam logic [4:0]  OTHER      = 5'h0C;

    // vector: {write, reg, write data, expected read}
    localparam int NV = 17;
    localparam logic [37:0] VEC [NV] = '{
        {1'b0, 5'h00, 16'h0000, 16'h3000},   // R6 reset value
        {1'b0, 5'h01, 16'h0000, 16'h7809},   // R9
        {1'b0, 5'h02, 16'h0000, TB_ID_HI},   // R12
        {1'b0, 5'h03, 16'h0000, TB_ID_LO},   // R12
        {1'b0, 5'h04, 16'h0000, 16'h01E1},   // R12
        {1'b0, 5'h19, 16'h0000, 16'h000B},   // R3
        {1'b0, 5'h05, 16'h0000, 16'h0000},   // R11
        {1'b1, 5'h04, 16'h0A5F, 16'h0000},
        {1'b0, 5'h04, 16'h0000, 16'h0A5F},   // R12
        {1'b1, 5'h00, 16'h4100, 16'h0000},
        {1'b0, 5'h00, 16'h0000, 16'h4100},   // R6
        {1'b1, 5'h01, 16'hFFFF, 16'h0000},
        {1'b0, 5'h01, 16'h0000, 16'h7809},   // R9 R11
        {1'b1, 5'h1F, 16'hFFFF, 16'h0000},
        {1'b0, 5'h1F, 16'h0000, 16'h0000},   // R11
        {1'b1, 5'h19, 16'h0015, 16'h0000},
        {1'b0, 5'h19, 16'h0000, 16'h000B}    // R11 R3
    };

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = PHYA;
    logic       mst_oe = 1'b0;
    logic       mst_bit = 1'b1;
    logic       st_link = 1'b0, st_an_done = 1'b0, st_jabber = 1'b0;
    logic       st_rfault = 1'b0, st_speed100 = 1'b0, st_fdx = 1'b0;
    logic       dut_o, dut_oe;
    logic       c_srst, c_iso, c_loop, c_spd, c_fdx;
    logic       mdio_line;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    assign mdio_line = dut_oe ? dut_o : (mst_oe ? mst_bit : 1'b1);

    always #(CLK_PERIOD / 2) mdc = ~mdc;

    mdio_mgmt_slave #(
        .ID_HI (TB_ID_HI),
        .ID_LO (TB_ID_LO)
    ) u_dut (
        .mdc             (mdc),
        .rst_n           (rst_n),
        .strap_phy_addr  (strap),
        .mdio_i          (mdio_line),
        .mdio_o          (dut_o),
        .mdio_oe         (dut_oe),
        .st_link         (st_link),
        .st_an_done      (st_an_done),
        .st_jabber       (st_jabber),
        .st_rfault       (st_rfault),
        .st_speed100     (st_speed100),
        .st_full_duplex  (st_fdx),
        .ctl_soft_rst    (c_srst),
        .ctl_isolate     (c_iso),
        .ctl_loopback    (c_loop),
        .ctl_speed100    (c_spd),
        .ctl_full_duplex (c_fdx)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge mdc) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge mdc);
            mst_oe  = 1'b1;
            mst_bit = v[i];
        end
    endtask

    task automatic mdio_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                              input logic [4:0] ra, input logic [15:0] d);
        for (int i = 0; i < pre; i++) send_bits(32'd1, 1);
        send_bits(32'b01, 2);
        send_bits({30'd0, op}, 2);
        send_bits({27'd0, phy}, 5);
        send_bits({27'd0, ra}, 5);
        send_bits(32'b10, 2);
        send_bits({16'd0, d}, 16);
        @(negedge mdc);
        mst_oe = 1'b0;
    endtask

    task automatic mdio_read(input logic [4:0] phy, input logic [4:0] ra,
                             output logic [15:0] d, output logic ta1_oe,
                             output logic ta2_lvl, output logic drove, output logic tail_oe);
        for (int i = 0; i < 32; i++) send_bits(32'd1, 1);
        send_bits(32'b01, 2);
        send_bits(32'b10, 2);
        send_bits({27'd0, phy}, 5);
        send_bits({27'd0, ra}, 5);
        @(negedge mdc);
        mst_oe  = 1'b0;
        ta1_oe  = dut_oe;
        @(negedge mdc);
        ta2_lvl = mdio_line;
        drove   = dut_oe;
        for (int i = 0; i < 16; i++) begin
            @(negedge mdc);
            d[15 - i] = mdio_line;
            drove     = drove | dut_oe;
        end
        @(negedge mdc);
        tail_oe = dut_oe;
    endtask

    task automatic hw_reset(input logic [4:0] s);
        @(negedge mdc);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
    endtask

    initial begin
        logic [15:0] rd;
        logic        t1, t2, dr, tl;

        hw_reset(PHYA);

        // reset state of the control outputs and the pad enable
        chk("R4 idle oe", {15'd0, dut_oe}, 16'h0000);
        chk("R6 reset outputs", {11'd0, c_srst, c_iso, c_loop, c_spd, c_fdx}, 16'h0002);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37]) begin
                mdio_write(32, 2'b01, PHYA, VEC[i][36:32], VEC[i][31:16]);
            end else begin
                mdio_read(PHYA, VEC[i][36:32], rd, t1, t2, dr, tl);
                chk($sformatf("R6/R9/R11/R12/R3 table entry %0d", i), rd, VEC[i][15:0]);
            end
        end
        chk("R6 outputs follow 0x4100", {11'd0, c_srst, c_iso, c_loop, c_spd, c_fdx}, 16'h0005);

        // R10 and R9 with live status
        st_link = 1'b1; st_an_done = 1'b1; st_rfault = 1'b1; st_jabber = 1'b0;
        st_speed100 = 1'b0; st_fdx = 1'b1;
        mdio_read(PHYA, 5'h10, rd, t1, t2, dr, tl);
        chk("R10 quick status", rd, 16'h005F);
        st_jabber = 1'b1; st_speed100 = 1'b1; st_rfault = 1'b0;
        mdio_read(PHYA, 5'h10, rd, t1, t2, dr, tl);
        chk("R10 quick status alt", rd, 16'h003D);
        mdio_read(PHYA, 5'h01, rd, t1, t2, dr, tl);
        chk("R9 status bits", rd, 16'h782F);
        st_link = 1'b0; st_an_done = 1'b0; st_jabber = 1'b0; st_speed100 = 1'b0; st_fdx = 1'b0;

        // R5 turnaround and release timing
        mdio_read(PHYA, 5'h04, rd, t1, t2, dr, tl);
        chk("R5 read data", rd, 16'h0A5F);
        chk("R4 first turnaround undriven", {15'd0, t1}, 16'h0000);
        chk("R5 second turnaround low", {15'd0, t2}, 16'h0000);
        chk("R5 released after data", {15'd0, tl}, 16'h0000);

        // R2 foreign address
        mdio_read(OTHER, 5'h00, rd, t1, t2, dr, tl);
        chk("R2 foreign read not driven", {15'd0, dr}, 16'h0000);
        chk("R2 foreign read floats high", rd, 16'hFFFF);
        mdio_write(32, 2'b01, OTHER, 5'h00, 16'h0000);
        chk("R2 foreign write ignored", {15'd0, c_loop}, 16'h0001);

        // R13 invalid opcodes
        mdio_write(32, 2'b11, PHYA, 5'h00, 16'h0000);
        mdio_write(32, 2'b00, PHYA, 5'h00, 16'h0000);
        chk("R13 invalid opcode ignored", {15'd0, c_loop}, 16'h0001);

        // R1 short preamble rejected, full one accepted
        send_bits(32'd0, 1);
        mdio_write(31, 2'b01, PHYA, 5'h00, 16'h0000);
        chk("R1 31-one preamble ignored", {15'd0, c_loop}, 16'h0001);
        mdio_write(32, 2'b01, PHYA, 5'h00, 16'h0000);
        chk("R1 32-one preamble accepted", {15'd0, c_loop}, 16'h0000);

        // R7 soft reset
        mdio_write(32, 2'b01, PHYA, 5'h00, 16'h4100);
        mdio_write(32, 2'b01, PHYA, 5'h04, 16'h1234);
        mdio_write(32, 2'b01, PHYA, 5'h00, 16'h8000);
        chk("R7 soft reset output high", {15'd0, c_srst}, 16'h0001);
        chk("R7 defaults during reset", {13'd0, c_loop, c_spd, c_fdx}, 16'h0002);
        mdio_read(PHYA, 5'h00, rd, t1, t2, dr, tl);
        chk("R7 busy bit reads 1", rd, 16'hB000);
        repeat (80) @(negedge mdc);
        chk("R7 soft reset output low", {15'd0, c_srst}, 16'h0000);
        mdio_read(PHYA, 5'h00, rd, t1, t2, dr, tl);
        chk("R7 self-cleared control", rd, 16'h3000);
        mdio_read(PHYA, 5'h04, rd, t1, t2, dr, tl);
        chk("R7 advertisement restored", rd, 16'h01E1);

        // R3 strap change after reset has no effect
        strap = 5'h15;
        mdio_read(PHYA, 5'h19, rd, t1, t2, dr, tl);
        chk("R3 latched address kept", rd, 16'h000B);
        mdio_read(5'h15, 5'h19, rd, t1, t2, dr, tl);
        chk("R3 new strap not answered", {15'd0, dr}, 16'h0000);

        // R8 zero address forces isolate
        hw_reset(5'h00);
        chk("R8 isolate after hw reset", {15'd0, c_iso}, 16'h0001);
        mdio_read(5'h00, 5'h00, rd, t1, t2, dr, tl);
        chk("R8 control with isolate", rd, 16'h3400);
        mdio_write(32, 2'b01, 5'h00, 5'h00, 16'h3000);
        chk("R8 isolate cleared by write", {15'd0, c_iso}, 16'h0000);
        mdio_write(32, 2'b01, 5'h00, 5'h00, 16'h8000);
        chk("R8 isolate after soft reset", {15'd0, c_iso}, 16'h0001);

        repeat (80) @(negedge mdc);
        finish_run();
    end

endmodule